// File: doc/BRIEF.md
# Four-Digit Number / Failure-Message Display Driver

This block drives a four-digit, common-anode seven-segment display from one clock domain. In its normal mode it decodes a 4-bit value (hex 0 through F) and shows it on a single, fixed digit. When an external fail flag is raised, it switches to a scanned text mode. In that mode it multiplexes the four digits and spells the word FAIL across them, moving to the next digit on each pulse of a refresh-tick enable.

Both output buses come from one set of registers, and those registers are written only on the rising clock edge. The segment code and the digit select therefore always change together and have exactly one driver. The game logic, any timers and the circuit that generates the refresh tick sit outside this block.

Top module: `svn_display_drv`

## Requirements
- R1: While `rst` is high at a rising edge, the next outputs are `seg_n` = 7'b1111111 (all segments dark) and `dig_sel_n` = 4'b1111 (no digit selected).
- R2: With `fail` low at a rising edge, `seg_n` after that edge is the active-low gfedcba code (bit 6 = g, bit 0 = a, 0 = lit) of `value`. The codes are 0:40 1:79 2:24 3:30 4:19 5:12 6:02 7:78 8:00 9:10 A:08 B:03 C:46 D:21 E:06 F:0E (hex).
- R3: With `fail` low at a rising edge, `dig_sel_n` after that edge is 4'b0111, which selects only the leftmost digit.
- R4: Every output change takes effect on a rising clock edge and reflects the inputs sampled at that edge: one cycle of latency, and no path from inputs to outputs that bypasses a register.
- R5: In message mode, scan position p (0 = left, 1 = mid-left, 2 = mid-right, 3 = right) drives `dig_sel_n` = 0111, 1011, 1101, 1110 respectively. It also drives `seg_n` = 0001110 (F), 0001000 (A), 1111001 (I), 1000111 (L) respectively.
- R6: In message mode, the scan position moves only at an edge where `tick` is high. At any other edge both outputs hold their values.
- R7: From the right position, a tick moves the scan back to the left position.
- R8: At the first edge where `fail` is high after being low (or after reset), the outputs show position left (F on 0111), whatever the state of `tick`.
- R9: At the first edge where `fail` is low after being high, the outputs return to number mode (R2, R3).
- R10: After the first edge following reset, `dig_sel_n` always has exactly one zero bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| value | input | 4 | Value shown in number mode |
| fail | input | 1 | Selects scanned FAIL message mode |
| tick | input | 1 | Refresh enable; advances the scan position |
| seg_n | output | 7 | Segment bus, active low, bit 6 = g ... bit 0 = a |
| dig_sel_n | output | 4 | Digit select, active low, bit 3 = leftmost |

## Verification
The bench builds the block with its default parameters: four digits, active-low polarity and the number shown on the leftmost digit. This is the configuration whose encodings the requirements fix. With it the bench can sweep all sixteen values of `value` and compare each result with a code table of its own. It can also walk the message scan through several full wraps against a position counter it keeps itself. The remaining cases are reached through ordered `fail`/`tick` patterns: holds with no tick, a restart in the middle of a scan, a drop back to number mode, and a reset during message mode.

// File: rtl/svn_pkg.sv
package svn_pkg;

   localparam int unsigned SEG_W   = 7;
   localparam int unsigned MSG_LEN = 4;

   typedef logic [SEG_W-1:0] seg_t;

   // Active-high gfedcba glyphs for hex digits.
   function automatic seg_t hex_glyph(input logic [3:0] v);
      seg_t g;
      unique case (v)
         4'h0: g = 7'h3F;
         4'h1: g = 7'h06;
         4'h2: g = 7'h5B;
         4'h3: g = 7'h4F;
         4'h4: g = 7'h66;
         4'h5: g = 7'h6D;
         4'h6: g = 7'h7D;
         4'h7: g = 7'h07;
         4'h8: g = 7'h7F;
         4'h9: g = 7'h6F;
         4'hA: g = 7'h77;
         4'hB: g = 7'h7C;
         4'hC: g = 7'h39;
         4'hD: g = 7'h5E;
         4'hE: g = 7'h79;
         default: g = 7'h71;
      endcase
      return g;
   endfunction

   // Active-high glyphs of the failure word, indexed left to right.
   function automatic seg_t msg_glyph(input int unsigned idx);
      seg_t g;
      case (idx)
         0:       g = 7'h71;   // F
         1:       g = 7'h77;   // A
         2:       g = 7'h06;   // I
         default: g = 7'h38;   // L
      endcase
      return g;
   endfunction

endpackage

// File: rtl/svn_scan.sv
module svn_scan #(
   parameter int unsigned DIGITS = 4,
   localparam int unsigned POS_W = (DIGITS > 1) ? $clog2(DIGITS) : 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             run,
   input  logic             tick,
   output logic [POS_W-1:0] pos_nxt
);

   localparam logic [POS_W-1:0] LAST = POS_W'(DIGITS - 1);

   logic [POS_W-1:0] pos_q;
   logic             run_q;

   always_comb begin
      if (!run || !run_q)
         pos_nxt = '0;
      else if (tick)
         pos_nxt = (pos_q == LAST) ? '0 : pos_q + 1'b1;
      else
         pos_nxt = pos_q;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         pos_q <= '0;
         run_q <= 1'b0;
      end else begin
         pos_q <= pos_nxt;
         run_q <= run;
      end
   end

endmodule

// File: rtl/svn_glyph.sv
module svn_glyph
   import svn_pkg::*;
#(
   parameter int unsigned DIGITS     = 4,
   parameter bit          ACTIVE_LOW = 1'b1,
   parameter int unsigned NUM_DIGIT  = 0,
   localparam int unsigned POS_W     = (DIGITS > 1) ? $clog2(DIGITS) : 1
) (
   input  logic              msg_mode,
   input  logic [POS_W-1:0]  pos,
   input  logic [3:0]        value,
   output seg_t              seg,
   output logic [DIGITS-1:0] sel
);

   seg_t              lit;
   logic [DIGITS-1:0] pick;   // active-high one-hot, MSB = leftmost

   always_comb begin
      pick = '0;
      if (msg_mode) begin
         lit = msg_glyph(int'(pos));
         pick[DIGITS-1-int'(pos)] = 1'b1;
      end else begin
         lit = hex_glyph(value);
         pick[DIGITS-1-NUM_DIGIT] = 1'b1;
      end
   end

   generate
      if (ACTIVE_LOW) begin : g_low
         assign seg = ~lit;
         assign sel = ~pick;
      end else begin : g_high
         assign seg = lit;
         assign sel = pick;
      end
   endgenerate

endmodule

// File: rtl/svn_display_drv.sv
module svn_display_drv
   import svn_pkg::*;
#(
   parameter int unsigned DIGITS     = 4,
   parameter bit          ACTIVE_LOW = 1'b1,
   parameter int unsigned NUM_DIGIT  = 0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [3:0]        value,
   input  logic              fail,
   input  logic              tick,
   output logic [SEG_W-1:0]  seg_n,
   output logic [DIGITS-1:0] dig_sel_n
);

   localparam int unsigned POS_W = (DIGITS > 1) ? $clog2(DIGITS) : 1;
   localparam seg_t        SEG_OFF = ACTIVE_LOW ? {SEG_W{1'b1}} : '0;
   localparam logic [DIGITS-1:0] SEL_OFF = ACTIVE_LOW ? {DIGITS{1'b1}} : '0;

   generate
      if (DIGITS != MSG_LEN) begin : g_bad_digits
         $error("DIGITS must equal the message length");
      end
      if (NUM_DIGIT >= DIGITS) begin : g_bad_num
         $error("NUM_DIGIT out of range");
      end
   endgenerate

   logic [POS_W-1:0]  pos_nxt;
   seg_t              seg_d;
   logic [DIGITS-1:0] sel_d;

   svn_scan #(.DIGITS(DIGITS)) u_scan (
      .clk     (clk),
      .rst     (rst),
      .run     (fail),
      .tick    (tick),
      .pos_nxt (pos_nxt)
   );

   svn_glyph #(
      .DIGITS     (DIGITS),
      .ACTIVE_LOW (ACTIVE_LOW),
      .NUM_DIGIT  (NUM_DIGIT)
   ) u_glyph (
      .msg_mode (fail),
      .pos      (pos_nxt),
      .value    (value),
      .seg      (seg_d),
      .sel      (sel_d)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         seg_n     <= SEG_OFF;
         dig_sel_n <= SEL_OFF;
      end else begin
         seg_n     <= seg_d;
         dig_sel_n <= sel_d;
      end
   end

endmodule

// File: rtl/svn_display_chk.sv
module svn_display_chk (
   input logic       clk,
   input logic       rst,
   input logic       fail,
   input logic       tick,
   input logic [6:0] seg_n,
   input logic [3:0] dig_sel_n
);

   logic [1:0] age;   // edges since reset release, saturating at 2

   always_ff @(posedge clk) begin
      if (rst)             age <= 2'd0;
      else if (age != 2'd2) age <= age + 2'd1;
   end

   // R1: reset darkens the display
   p_reset_dark_r1: assert property (@(posedge clk)
      $past(rst) |-> (seg_n == 7'h7F && dig_sel_n == 4'hF));

   // R10: exactly one digit selected once running
   p_one_digit_r10: assert property (@(posedge clk) disable iff (rst)
      (age != 2'd0) |-> ($countones(~dig_sel_n) == 1));

   // R3: number mode selects the leftmost digit
   p_num_sel_r3: assert property (@(posedge clk) disable iff (rst)
      (age != 2'd0 && !$past(fail)) |-> (dig_sel_n == 4'b0111));

   // R5: letter matches the selected position in message mode
   p_letter_r5: assert property (@(posedge clk) disable iff (rst)
      (age != 2'd0 && $past(fail)) |->
         ((dig_sel_n == 4'b0111 && seg_n == 7'b0001110) ||
          (dig_sel_n == 4'b1011 && seg_n == 7'b0001000) ||
          (dig_sel_n == 4'b1101 && seg_n == 7'b1111001) ||
          (dig_sel_n == 4'b1110 && seg_n == 7'b1000111)));

   // R8: entry to message mode starts at the left position
   p_restart_r8: assert property (@(posedge clk) disable iff (rst)
      (age != 2'd0 && $past(fail) && !$past(fail, 2)) |-> (dig_sel_n == 4'b0111));

   // R6: without a tick the scan holds
   p_hold_r6: assert property (@(posedge clk) disable iff (rst)
      (age == 2'd2 && $past(fail) && $past(fail, 2) && !$past(tick)) |->
         $stable(dig_sel_n));

   // R7: a tick at the right position wraps to the left
   p_wrap_r7: assert property (@(posedge clk) disable iff (rst)
      (age == 2'd2 && $past(fail) && $past(fail, 2) && $past(tick) &&
       $past(dig_sel_n) == 4'b1110) |-> (dig_sel_n == 4'b0111));

endmodule

bind svn_display_drv svn_display_chk u_chk (
   .clk       (clk),
   .rst       (rst),
   .fail      (fail),
   .tick      (tick),
   .seg_n     (seg_n),
   .dig_sel_n (dig_sel_n)
);

// File: tb/tb_svn_display_drv.sv
module tb_svn_display_drv;

   logic       clk = 1'b0;
   logic       rst;
   logic [3:0] value;
   logic       fail;
   logic       tick;
   logic [6:0] seg_n;
   logic [3:0] dig_sel_n;

   int checks = 0;
   int errors = 0;
   int exp_pos;

   always #5 clk = ~clk;

   svn_display_drv dut (
      .clk       (clk),
      .rst       (rst),
      .value     (value),
      .fail      (fail),
      .tick      (tick),
      .seg_n     (seg_n),
      .dig_sel_n (dig_sel_n)
   );

   function automatic logic [6:0] exp_hex(input int v);
      case (v)
         0: return 7'h40;  1: return 7'h79;  2: return 7'h24;  3: return 7'h30;
         4: return 7'h19;  5: return 7'h12;  6: return 7'h02;  7: return 7'h78;
         8: return 7'h00;  9: return 7'h10; 10: return 7'h08; 11: return 7'h03;
        12: return 7'h46; 13: return 7'h21; 14: return 7'h06; default: return 7'h0E;
      endcase
   endfunction

   function automatic logic [6:0] exp_letter(input int p);
      case (p)
         0: return 7'b0001110;
         1: return 7'b0001000;
         2: return 7'b1111001;
         default: return 7'b1000111;
      endcase
   endfunction

   function automatic logic [3:0] exp_sel(input int p);
      return ~(4'b1000 >> p);
   endfunction

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic check(input string req, input logic [10:0] act, input logic [10:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual seg=%b sel=%b expected seg=%b sel=%b",
                  req, act[10:4], act[3:0], exp[10:4], exp[3:0]);
      end
   endtask

   task automatic check_msg(input string req, input int p);
      check(req, {seg_n, dig_sel_n}, {exp_letter(p), exp_sel(p)});
   endtask

   initial begin : watchdog
      #1_000_000;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      rst = 1'b1; value = 4'h5; fail = 1'b0; tick = 1'b0;
      @(negedge clk);
      step();
      check("R1 reset", {seg_n, dig_sel_n}, {7'h7F, 4'hF});

      // R2/R3/R4: sweep every value in number mode
      rst = 1'b0;
      for (int v = 0; v < 16; v++) begin
         value = v[3:0];
         tick  = v[0];
         step();
         check("R2 R3 number", {seg_n, dig_sel_n}, {exp_hex(v), 4'b0111});
      end

      // R4: input change invisible until the edge
      value = 4'h8;
      #1;
      check("R4 latency", {seg_n, dig_sel_n}, {exp_hex(15), 4'b0111});
      step();
      check("R4 latency", {seg_n, dig_sel_n}, {exp_hex(8), 4'b0111});

      // R8: entry with tick high still starts left
      fail = 1'b1; tick = 1'b1;
      step();
      exp_pos = 0;
      check_msg("R8 entry", exp_pos);

      // R5/R7: ticks every cycle, three wraps
      for (int i = 0; i < 12; i++) begin
         step();
         exp_pos = (exp_pos + 1) % 4;
         check_msg("R5 R7 scan", exp_pos);
      end

      // R6: sparse ticks, holding between them
      for (int i = 0; i < 15; i++) begin
         tick = (i % 3 == 2);
         step();
         if (tick) exp_pos = (exp_pos + 1) % 4;
         check_msg("R6 hold", exp_pos);
      end

      // R9: drop back to number mode
      fail = 1'b0; tick = 1'b1; value = 4'hC;
      step();
      check("R9 exit", {seg_n, dig_sel_n}, {exp_hex(12), 4'b0111});

      // R8: re-entry restarts at left, tick low
      fail = 1'b1; tick = 1'b0;
      step();
      exp_pos = 0;
      check_msg("R8 reentry", exp_pos);
      tick = 1'b1;
      step(); step();
      exp_pos = 2;
      check_msg("R5 midright", exp_pos);
      fail = 1'b0; step();
      fail = 1'b1; tick = 1'b1; step();
      check_msg("R8 restart midscan", 0);

      // R1: reset in message mode
      rst = 1'b1;
      step();
      check("R1 reset in msg", {seg_n, dig_sel_n}, {7'h7F, 4'hF});
      rst = 1'b0; tick = 1'b1;
      step();
      check_msg("R8 after reset", 0);
      fail = 1'b0; value = 4'h0;
      step();
      check("R10 R3 final", {seg_n, dig_sel_n}, {exp_hex(0), 4'b0111});

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule